// File: doc/BRIEF.md
# Mixed-width dual-clock FIFO

This block buffers a stream between two unrelated clock domains when the producer and the consumer use different word widths. The two widths differ by a power of two, and either side may be the wider one. Storage is kept in units of the narrower word. A wide write is split into narrow units, lowest bits first. A wide read gathers consecutive narrow units, with the first unit written placed in the lowest bits.

Each domain keeps its own pointer, counted in its own word size, and publishes it as a Gray code. The other domain samples it through a flop chain whose depth is a parameter. Full and empty are worked out in narrow-unit space: the write side is full when there is no room for one more write word, and the read side is empty until one whole read word is stored. Read data is shown ahead: `rd_data` presents the head word whenever `rd_empty` is low, and `rd_req` consumes it. A single clear input resets both domains at once. When the clear-synchronizer option is on, each domain leaves reset only after three of its own clock edges, and `wr_full` stays high for that time.

Top module: `mwfifo_dc`

## Requirements
- R1: After the clear is released and both domains have left reset, `wr_empty` and `rd_empty` are 1, `wr_full` and `rd_full` are 0, and `wr_used` and `rd_used` are 0.
- R2: When the write word is wider, a write word of `RATIO` narrow units is read out as `RATIO` read words, bits [NW-1:0] first, then the next higher slice, and so on. `rd_data` shows the head word while `rd_empty` is 0.
- R3: When the read word is wider, `rd_empty` stays 1 until `RATIO` narrow words are stored. The first narrow word written then appears in `rd_data[NW-1:0]` and the next one in the slice above it.
- R4: `wr_used` counts stored data in write words and `rd_used` in read words. With 16-bit writes and 8-bit reads, two writes give `wr_used`=2 and `rd_used`=4 once the pointers have crossed, and four reads drain the FIFO.
- R5: `wr_full` is 1 when fewer free narrow units remain than one write word needs. A `wr_req` while `wr_full` is 1 stores nothing and leaves the count unchanged.
- R6: A `rd_req` while `rd_empty` is 1 does not move the read pointer, so the next word written is the next word read.
- R7: Each published pointer changes in at most one bit per clock of its own domain.
- R8: With the clear synchronizer enabled, raising `aclr` sets `wr_full` at once, without waiting for a clock. `wr_full` then stays 1 for two write-clock edges after `aclr` falls and returns to 0 at the third.
- R9: Under interleaved random writes and reads, every read word equals the narrow units written, in write order.
- R10: `wr_full` rises at the first write-clock edge that stores the last word that fits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| aclr | input | 1 | Asynchronous clear for both domains, active high |
| wr_data | input | WR_W | Write word |
| wr_req | input | 1 | Write request, ignored while wr_full |
| wr_full | output | 1 | No room for one write word |
| wr_empty | output | 1 | Write-domain view of empty (lags) |
| wr_used | output | WCW | Stored data in write words (write-domain view) |
| rd_req | input | 1 | Read acknowledge, ignored while rd_empty |
| rd_data | output | RD_W | Head read word |
| rd_full | output | 1 | Read-domain view of full (lags) |
| rd_empty | output | 1 | Fewer than one read word stored |
| rd_used | output | RCW | Stored data in read words (read-domain view) |

## Verification
The assertions assume that `aclr` is raised and lowered away from the active edges of both clocks, and that requests are held steady around each edge. The bench changes `wr_req`, `rd_req`, data and the clear only on falling clock edges. It decides whether a write or read takes effect from the flag it sees in the same domain half a cycle before the edge. The random phase drives requests against a full or empty FIFO on purpose, so the no-overflow and no-underflow properties are exercised with stimulus the design must ignore. After each burst the bench waits for the pointers to cross before it reads any cross-domain count.

// File: rtl/mwf_pkg.sv
package mwf_pkg;
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int log2c(input int v);
      int r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/mwf_rst_sync.sv
module mwf_rst_sync #(
   parameter int STAGES = 3,
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic aclr,
   output logic rst_n
);
   generate
      if (ENABLE) begin : g_sync
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or posedge aclr) begin
            if (aclr) chain <= '0;
            else      chain <= {chain[STAGES-2:0], 1'b1};
         end
         assign rst_n = chain[STAGES-1];
      end else begin : g_direct
         logic unused_clk;
         assign unused_clk = clk;
         assign rst_n      = ~aclr;
      end
   endgenerate
endmodule

// File: rtl/mwf_sync.sv
module mwf_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/mwf_side.sv
module mwf_side #(
   parameter int UNIT_AW   = 5,
   parameter int WR_SHIFT  = 1,
   parameter int RD_SHIFT  = 0,
   parameter bit IS_WRITE  = 1'b1,
   parameter bit HOLD_FULL = 1'b0,
   localparam int OWN_SHIFT = IS_WRITE ? WR_SHIFT : RD_SHIFT,
   localparam int OTH_SHIFT = IS_WRITE ? RD_SHIFT : WR_SHIFT,
   localparam int PW        = UNIT_AW - OWN_SHIFT + 1,
   localparam int OPW       = UNIT_AW - OTH_SHIFT + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req,
   input  logic [OPW-1:0] other_gray,
   output logic [PW-1:0]  ptr,
   output logic [PW-1:0]  gray,
   output logic           full,
   output logic           empty,
   output logic [PW-1:0]  count
);
   localparam int UW     = UNIT_AW + 1;
   localparam int NDEPTH = 1 << UNIT_AW;
   localparam int WR_U   = 1 << WR_SHIFT;
   localparam int RD_U   = 1 << RD_SHIFT;

   logic [OPW-1:0] oth_bin;
   logic [UW-1:0]  own_u, oth_u, used_u;
   logic [PW-1:0]  ptr_nx;
   logic           full_raw, step;

   always_comb begin
      for (int k = 0; k < OPW; k++) oth_bin[k] = ^(other_gray >> k);
   end

   assign own_u    = UW'(ptr) << OWN_SHIFT;
   assign oth_u    = UW'(oth_bin) << OTH_SHIFT;
   assign used_u   = IS_WRITE ? (own_u - oth_u) : (oth_u - own_u);
   assign full_raw = used_u > UW'(NDEPTH - WR_U);
   assign empty    = used_u < UW'(RD_U);
   assign full     = full_raw | (HOLD_FULL & ~rst_n);
   assign count    = PW'(used_u >> OWN_SHIFT);
   assign step     = req & ~(IS_WRITE ? full_raw : empty);
   assign ptr_nx   = ptr + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         gray <= '0;
      end else if (step) begin
         ptr  <= ptr_nx;
         gray <= ptr_nx ^ (ptr_nx >> 1);
      end
   end

   AST_PTR_GRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gray ^ $past(gray)) <= 1); // R7
   AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      used_u <= UW'(NDEPTH)); // R5

   generate
      if (IS_WRITE) begin : g_wr_chk
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (req && full) |=> $stable(ptr)); // R5
      end else begin : g_rd_chk
         AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (req && empty) |=> $stable(ptr)); // R6
      end
   endgenerate
endmodule

// File: rtl/mwfifo_dc.sv
module mwfifo_dc #(
   parameter int WR_W        = 16,
   parameter int RD_W        = 8,
   parameter int UNIT_AW     = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit CLR_SYNC    = 1'b1,
   localparam int NW       = (WR_W < RD_W) ? WR_W : RD_W,
   localparam int WR_SHIFT = mwf_pkg::log2c(WR_W / NW),
   localparam int RD_SHIFT = mwf_pkg::log2c(RD_W / NW),
   localparam int WCW      = UNIT_AW - WR_SHIFT + 1,
   localparam int RCW      = UNIT_AW - RD_SHIFT + 1
) (
   input  logic            wr_clk,
   input  logic            rd_clk,
   input  logic            aclr,
   input  logic [WR_W-1:0] wr_data,
   input  logic            wr_req,
   output logic            wr_full,
   output logic            wr_empty,
   output logic [WCW-1:0]  wr_used,
   input  logic            rd_req,
   output logic [RD_W-1:0] rd_data,
   output logic            rd_full,
   output logic            rd_empty,
   output logic [RCW-1:0]  rd_used
);
   localparam int WR_U       = 1 << WR_SHIFT;
   localparam int RD_U       = 1 << RD_SHIFT;
   localparam int NDEPTH     = 1 << UNIT_AW;
   localparam int UW         = UNIT_AW + 1;
   localparam int CLR_STAGES = 3;

   generate
      if (!mwf_pkg::is_pow2(WR_W / NW) || !mwf_pkg::is_pow2(RD_W / NW) ||
          (WR_W % NW) != 0 || (RD_W % NW) != 0) begin : g_bad_ratio
         $error("mwfifo_dc: width ratio must be a power of two");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("mwfifo_dc: SYNC_STAGES must be at least 1");
      end
      if (UNIT_AW <= WR_SHIFT || UNIT_AW <= RD_SHIFT) begin : g_bad_depth
         $error("mwfifo_dc: depth must exceed two of the widest word");
      end
   endgenerate

   logic           wr_rst_n, rd_rst_n;
   logic [WCW-1:0] wptr, wgray, wgray_rd;
   logic [RCW-1:0] rptr, rgray, rgray_wr;
   logic [NW-1:0]  mem [NDEPTH];
   logic [UW-1:0]  wr_base, rd_base;
   logic           wr_step;

   mwf_rst_sync #(.STAGES(CLR_STAGES), .ENABLE(CLR_SYNC)) u_wr_rst (
      .clk(wr_clk), .aclr(aclr), .rst_n(wr_rst_n));
   mwf_rst_sync #(.STAGES(CLR_STAGES), .ENABLE(CLR_SYNC)) u_rd_rst (
      .clk(rd_clk), .aclr(aclr), .rst_n(rd_rst_n));

   mwf_sync #(.W(WCW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rd));
   mwf_sync #(.W(RCW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_wr));

   mwf_side #(.UNIT_AW(UNIT_AW), .WR_SHIFT(WR_SHIFT), .RD_SHIFT(RD_SHIFT),
              .IS_WRITE(1'b1), .HOLD_FULL(CLR_SYNC)) u_wr_side (
      .clk(wr_clk), .rst_n(wr_rst_n), .req(wr_req), .other_gray(rgray_wr),
      .ptr(wptr), .gray(wgray), .full(wr_full), .empty(wr_empty), .count(wr_used));

   mwf_side #(.UNIT_AW(UNIT_AW), .WR_SHIFT(WR_SHIFT), .RD_SHIFT(RD_SHIFT),
              .IS_WRITE(1'b0), .HOLD_FULL(1'b0)) u_rd_side (
      .clk(rd_clk), .rst_n(rd_rst_n), .req(rd_req), .other_gray(wgray_rd),
      .ptr(rptr), .gray(rgray), .full(rd_full), .empty(rd_empty), .count(rd_used));

   assign wr_step = wr_req & ~wr_full;
   assign wr_base = UW'(wptr) << WR_SHIFT;
   assign rd_base = UW'(rptr) << RD_SHIFT;

   always_ff @(posedge wr_clk) begin
      if (wr_step) begin
         for (int i = 0; i < WR_U; i++)
            mem[wr_base[UNIT_AW-1:0] + UNIT_AW'(i)] <= wr_data[i*NW +: NW];
      end
   end

   generate
      for (genvar g = 0; g < RD_U; g++) begin : g_rd_slice
         assign rd_data[g*NW +: NW] = mem[rd_base[UNIT_AW-1:0] + UNIT_AW'(g)];
      end
   endgenerate
endmodule

// File: tb/mwfifo_dc_tb_top.sv
module mwfifo_dc_tb_top;
   logic wr_clk = 1'b0, rd_clk = 1'b0, aclr = 1'b0;
   always #10 wr_clk = ~wr_clk;
   always #16 rd_clk = ~rd_clk;

   logic [15:0] a_wd;  logic a_wreq = 1'b0, a_rreq = 1'b0;
   logic a_wfull, a_wempty, a_rfull, a_rempty;
   logic [4:0] a_wused; logic [5:0] a_rused; logic [7:0] a_rd;

   logic [7:0] b_wd;  logic b_wreq = 1'b0, b_rreq = 1'b0;
   logic b_wfull, b_wempty, b_rfull, b_rempty;
   logic [4:0] b_wused; logic [3:0] b_rused; logic [15:0] b_rd;

   mwfifo_dc #(.WR_W(16), .RD_W(8), .UNIT_AW(5)) dut_i (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .aclr(aclr), .wr_data(a_wd), .wr_req(a_wreq),
      .wr_full(a_wfull), .wr_empty(a_wempty), .wr_used(a_wused), .rd_req(a_rreq),
      .rd_data(a_rd), .rd_full(a_rfull), .rd_empty(a_rempty), .rd_used(a_rused));

   mwfifo_dc #(.WR_W(8), .RD_W(16), .UNIT_AW(4)) dut_n (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .aclr(aclr), .wr_data(b_wd), .wr_req(b_wreq),
      .wr_full(b_wfull), .wr_empty(b_wempty), .wr_used(b_wused), .rd_req(b_rreq),
      .rd_data(b_rd), .rd_full(b_rfull), .rd_empty(b_rempty), .rd_used(b_rused));

   int tests = 0, fails = 0;
   bit done = 1'b0;
   byte unsigned mq[$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(negedge rd_clk);
      repeat (8) @(negedge wr_clk);
   endtask

   // push two bytes, low half first, when the write is accepted
   task automatic wr_word(input logic [15:0] d, output bit acc);
      @(negedge wr_clk);
      acc    = !a_wfull;
      a_wd   = d;
      a_wreq = 1'b1;
      if (acc) begin
         mq.push_back(d[7:0]);
         mq.push_back(d[15:8]);
      end
      @(posedge wr_clk);
      #1 a_wreq = 1'b0;
   endtask

   task automatic rd_word(input string tag);
      byte unsigned e;
      @(negedge rd_clk);
      if (!a_rempty) begin
         e = (mq.size() > 0) ? mq.pop_front() : 8'hxx;
         chk(tag, 32'(a_rd), 32'(e));
      end
      a_rreq = 1'b1;
      @(posedge rd_clk);
      #1 a_rreq = 1'b0;
   endtask

   function automatic logic [31:0] rnd16();
      return 32'($urandom & 32'hFFFF);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL R9 watchdog act=running exp=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : main
      bit acc;
      void'($urandom(32'd2024));
      #1 aclr = 1'b1;
      repeat (3) @(negedge wr_clk);
      chk("R8 full during clear", 32'(a_wfull), 32'd1);
      chk("R1 rd_empty during clear", 32'(a_rempty), 32'd1);
      aclr = 1'b0;
      @(negedge wr_clk); @(negedge wr_clk);
      chk("R8 full held after release", 32'(a_wfull), 32'd1);
      @(negedge wr_clk);
      chk("R8 full drops at third edge", 32'(a_wfull), 32'd0);
      settle();
      chk("R1 wr_empty", 32'(a_wempty), 32'd1);
      chk("R1 wr_used", 32'(a_wused), 32'd0);
      chk("R1 rd_empty", 32'(a_rempty), 32'd1);
      chk("R1 rd_full", 32'(a_rfull), 32'd0);
      chk("R1 rd_used", 32'(a_rused), 32'd0);

      // R4 / R2: two wide writes
      wr_word(16'hBBAA, acc);
      wr_word(16'hDDCC, acc);
      settle();
      chk("R4 wr_used", 32'(a_wused), 32'd2);
      chk("R4 rd_used", 32'(a_rused), 32'd4);
      chk("R2 head low half", 32'(a_rd), 32'hAA);
      repeat (4) rd_word("R2 unpack order");
      settle();
      chk("R4 drained rd_empty", 32'(a_rempty), 32'd1);
      chk("R4 drained wr_used", 32'(a_wused), 32'd0);

      // R10 / R5: fill to full
      for (int k = 0; k < 16; k++) begin
         wr_word(16'(32'h0101 * (k + 1)), acc);
         chk("R5 accepted before full", 32'(acc), 32'd1);
      end
      @(negedge wr_clk);
      chk("R10 full after last fitting write", 32'(a_wfull), 32'd1);
      wr_word(16'hFFFF, acc);
      chk("R5 write while full rejected", 32'(acc), 32'd0);
      @(negedge wr_clk);
      chk("R5 count unchanged", 32'(a_wused), 32'd16);
      settle();
      repeat (32) rd_word("R5 no overwrite");
      settle();
      chk("R5 empty after drain", 32'(a_rempty), 32'd1);

      // R6: reads while empty
      repeat (3) rd_word("R6 unexpected data");
      wr_word(16'h3412, acc);
      settle();
      chk("R6 head after empty reads", 32'(a_rd), 32'h12);
      repeat (2) rd_word("R6 order");

      // R3: narrow write, wide read
      @(negedge wr_clk); b_wd = 8'h11; b_wreq = 1'b1;
      @(negedge wr_clk); b_wreq = 1'b0;
      settle();
      chk("R3 empty with one narrow word", 32'(b_rempty), 32'd1);
      chk("R3 rd_used with one narrow word", 32'(b_rused), 32'd0);
      @(negedge wr_clk); b_wd = 8'h22; b_wreq = 1'b1;
      @(negedge wr_clk); b_wreq = 1'b0;
      settle();
      chk("R3 not empty with two", 32'(b_rempty), 32'd0);
      chk("R3 packed word", 32'(b_rd), 32'h2211);
      chk("R3 rd_used", 32'(b_rused), 32'd1);
      @(negedge rd_clk); b_rreq = 1'b1;
      @(negedge rd_clk); b_rreq = 1'b0;
      settle();
      chk("R3 empty after read", 32'(b_rempty), 32'd1);

      // R9: random traffic
      fork
         begin
            repeat (500) begin
               if (($urandom % 4) != 0) wr_word(16'(rnd16()), acc);
               else @(negedge wr_clk);
            end
         end
         begin
            repeat (700) begin
               if (($urandom % 3) != 0) rd_word("R9 random order");
               else @(negedge rd_clk);
            end
         end
      join
      while (mq.size() > 0) rd_word("R9 drain order");
      settle();
      chk("R9 empty at end", 32'(a_rempty), 32'd1);

      // R8 / R1: clear with data present
      repeat (3) wr_word(16'(rnd16()), acc);
      @(negedge wr_clk); aclr = 1'b1;
      #1;
      chk("R8 full immediate", 32'(a_wfull), 32'd1);
      chk("R1 rd_empty immediate", 32'(a_rempty), 32'd1);
      chk("R1 wr_used immediate", 32'(a_wused), 32'd0);
      mq.delete();
      @(negedge wr_clk); aclr = 1'b0;
      @(negedge wr_clk); @(negedge wr_clk);
      chk("R8 full held", 32'(a_wfull), 32'd1);
      @(negedge wr_clk);
      chk("R8 full released", 32'(a_wfull), 32'd0);
      settle();
      wr_word(16'h6655, acc);
      settle();
      repeat (2) rd_word("R1 restart order");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule